// File: doc/BRIEF.md
# Single-Precision to Block Floating-Point Quantizer

The quantizer turns a stream of single-precision floating-point words into block floating-point groups. It takes `BLOCK_LEN` words, one per accepted handshake, and keeps all of them. It also tracks the largest biased exponent among the nonzero words. That largest exponent becomes the group's shared exponent. The block then replays the stored words in arrival order. It right-aligns each significand against the shared exponent and rounds it to a signed `MANT_W`-bit mantissa. Each mantissa leaves on the output stream with the shared exponent next to it.

Both edges use valid/ready. On the input side, `in_ready` is high only while a block is being collected. A word is taken on every cycle in which `in_valid` and `in_ready` are both high. `in_ready` drops as soon as the last word of a block is taken. It stays low until the consumer has taken the last mantissa. On the output side, `out_valid` stays high for the whole drain. When `out_ready` is low, the current mantissa, `out_last` and `out_exp` hold unchanged. The two directions never overlap, so one block costs at least 2·`BLOCK_LEN` cycles.

A mantissa `m` with shared exponent `E` stands for m·2^(E−127−(MANT_W−2)). A word at the block's maximum therefore lands in [2^(MANT_W−2), 2^(MANT_W−1)). Words far below the maximum lose their low bits or become zero.

Top module: `bfpq_quantizer`

## Requirements
- R1: While reset is asserted, and after it is released until a full block has been taken, `in_ready` is 1 and `out_valid` is 0.
- R2: `in_ready` and `out_valid` are never high together. Exactly `BLOCK_LEN` input handshakes fill a block, and `in_ready` returns only after the drain completes.
- R3: `out_exp` equals the largest value of bits 30:23 over the block's words. A block in which every word has bits 30:23 equal to zero gives `out_exp` = 0 and all mantissas 0.
- R4: For a word with sign bit 31, exponent field e (bits 30:23) and fraction f (bits 22:0), the magnitude is (2^23+f)·2^(e−E−17) for `MANT_W`=8. It is rounded to nearest with ties away from zero, and the sign is applied in two's complement.
- R5: A magnitude that rounds above 127 saturates to 127, so the output is +127 or −127. The code −128 never appears.
- R6: A word whose exponent field is 0 (zero or denormal, either sign) gives mantissa 0.
- R7: A word whose aligned magnitude is below one half flushes to 0. A magnitude of exactly one half rounds to ±1.
- R8: Mantissas leave in input order. `out_last` is 1 exactly on the `BLOCK_LEN`-th mantissa of a block.
- R9: While `out_valid` is 1 and `out_ready` is 0, `out_valid`, `out_mant` and `out_last` keep their values into the next cycle.
- R10: `out_exp` stays constant for every cycle of a block's drain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input word offered |
| in_ready | output | 1 | Block accepts a word this cycle |
| in_data | input | 32 | Single-precision word: sign 31, exponent 30:23, fraction 22:0 |
| out_valid | output | 1 | A mantissa is offered |
| out_ready | input | 1 | Consumer takes the mantissa this cycle |
| out_mant | output | MANT_W | Signed two's-complement mantissa |
| out_exp | output | 8 | Shared biased exponent of the block being drained |
| out_last | output | 1 | Marks the final mantissa of a block |

## Verification
The input patterns are chosen so that each one separates a different part of the behaviour:

- **Zero and denormal block.** Positive zero, negative zero and denormals of both signs appear together. This isolates the all-zero exponent path from the normal path.
- **Same-exponent block.** All words share one exponent, and the fractions are picked to land on ties (64.5, low-edge 0.5), just above and below half, and on 127.99. A design that truncates, rounds ties to even, or wraps instead of saturating is exposed here.
- **Wide-spread block.** One large word sits among much smaller ones. Some positions shift into single digits and others flush to zero, which checks the shift amount and the low-edge rounding.
- **Random blocks.** Random exponents, occasional zero exponents and random signs exercise the general case.

All patterns run under alternating phases of full throughput and random stalls on both sides. This separates the back-pressure holding from the data path.

// File: rtl/bfpq_pkg.sv
package bfpq_pkg;

  localparam int FP_W      = 32;
  localparam int FP_EXP_W  = 8;
  localparam int FP_FRAC_W = 23;
  localparam int FP_SIG_W  = FP_FRAC_W + 1;

  // Decoded view of one single-precision word; zero covers denormals too.
  typedef struct packed {
    logic                sign;
    logic                zero;
    logic [FP_EXP_W-1:0] exp;
    logic [FP_SIG_W-1:0] sig;
  } fp_fields_t;

  typedef enum logic {
    ST_COLLECT = 1'b0,
    ST_DRAIN   = 1'b1
  } bfpq_state_e;

endpackage

// File: rtl/bfpq_unpack.sv
module bfpq_unpack
  import bfpq_pkg::*;
(
  input  logic [FP_W-1:0] word,
  output fp_fields_t      fields
);

  logic [FP_EXP_W-1:0]  exp_field;
  logic [FP_FRAC_W-1:0] frac_field;

  always_comb begin
    exp_field   = word[FP_W-2 -: FP_EXP_W];
    frac_field  = word[FP_FRAC_W-1:0];
    fields.sign = word[FP_W-1];
    fields.zero = (exp_field == '0);
    fields.exp  = exp_field;
    // hidden one restored only for normal numbers
    fields.sig  = fields.zero ? '0 : {1'b1, frac_field};
  end

endmodule

// File: rtl/bfpq_expmax.sv
module bfpq_expmax
  import bfpq_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clear,
  input  logic                upd,
  input  logic                zero_in,
  input  logic [FP_EXP_W-1:0] exp_in,
  output logic [FP_EXP_W-1:0] exp_max
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exp_max <= '0;
    end else if (clear) begin
      exp_max <= '0;
    end else if (upd && !zero_in && (exp_in > exp_max)) begin
      exp_max <= exp_in;
    end
  end

endmodule

// File: rtl/bfpq_store.sv
module bfpq_store #(
  parameter int DEPTH = 8,
  parameter int W     = 32,
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [W-1:0]     wr_data,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [W-1:0]     rd_data
);

  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) begin
      mem[wr_idx] <= wr_data;
    end
  end

  assign rd_data = mem[rd_idx];

endmodule

// File: rtl/bfpq_align_round.sv
module bfpq_align_round
  import bfpq_pkg::*;
#(
  parameter int MANT_W = 8
) (
  input  fp_fields_t          fields,
  input  logic [FP_EXP_W-1:0] shared_exp,
  output logic [MANT_W-1:0]   mant
);

  localparam int SIG_W   = FP_SIG_W;
  localparam int MAG_W   = MANT_W - 1;
  localparam int BASE_SH = SIG_W - MAG_W;
  localparam int SH_W    = FP_EXP_W + 2;
  localparam int MAG_MAX = (1 << MAG_W) - 1;

  logic [FP_EXP_W-1:0] diff;
  logic [SH_W-1:0]     sh;
  logic [SIG_W:0]      aligned;
  logic [SIG_W:0]      mag;
  logic [MAG_W-1:0]    mag_sat;

  always_comb begin
    diff    = shared_exp - fields.exp;
    sh      = SH_W'(BASE_SH) + SH_W'(diff);
    // one guard bit kept below the result; shifts past the width give zero
    aligned = {fields.sig, 1'b0} >> sh;
    mag     = {1'b0, aligned[SIG_W:1]} + (SIG_W+1)'(aligned[0]);
    mag_sat = (mag > (SIG_W+1)'(MAG_MAX)) ? MAG_W'(MAG_MAX) : mag[MAG_W-1:0];
    if (fields.zero) begin
      mant = '0;
    end else if (fields.sign) begin
      mant = MANT_W'(0) - {1'b0, mag_sat};
    end else begin
      mant = {1'b0, mag_sat};
    end
  end

endmodule

// File: rtl/bfpq_quantizer.sv
module bfpq_quantizer
  import bfpq_pkg::*;
#(
  parameter int BLOCK_LEN = 8,
  parameter int MANT_W    = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [FP_W-1:0]     in_data,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [MANT_W-1:0]   out_mant,
  output logic [FP_EXP_W-1:0] out_exp,
  output logic                out_last
);

  localparam int               IDX_W    = (BLOCK_LEN > 1) ? $clog2(BLOCK_LEN) : 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(BLOCK_LEN - 1);

  bfpq_state_e       state;
  logic [IDX_W-1:0]  idx;
  logic              in_fire;
  logic              out_fire;
  logic              at_last;
  logic [FP_W-1:0]   rd_word;
  fp_fields_t        in_fields;
  fp_fields_t        rd_fields;
  logic [FP_EXP_W-1:0] shared_exp;

  assign in_ready  = (state == ST_COLLECT);
  assign out_valid = (state == ST_DRAIN);
  assign in_fire   = in_valid && in_ready;
  assign out_fire  = out_valid && out_ready;
  assign at_last   = (idx == LAST_IDX);

  // one index serves both the fill and the replay
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_COLLECT;
      idx   <= '0;
    end else begin
      case (state)
        ST_COLLECT: begin
          if (in_fire) begin
            if (at_last) begin
              idx   <= '0;
              state <= ST_DRAIN;
            end else begin
              idx <= idx + 1'b1;
            end
          end
        end
        ST_DRAIN: begin
          if (out_fire) begin
            if (at_last) begin
              idx   <= '0;
              state <= ST_COLLECT;
            end else begin
              idx <= idx + 1'b1;
            end
          end
        end
        default: state <= ST_COLLECT;
      endcase
    end
  end

  bfpq_unpack u_unpack_in (
    .word   (in_data),
    .fields (in_fields)
  );

  bfpq_expmax u_expmax (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (out_fire && at_last),
    .upd     (in_fire),
    .zero_in (in_fields.zero),
    .exp_in  (in_fields.exp),
    .exp_max (shared_exp)
  );

  bfpq_store #(
    .DEPTH (BLOCK_LEN),
    .W     (FP_W),
    .IDX_W (IDX_W)
  ) u_store (
    .clk     (clk),
    .wr_en   (in_fire),
    .wr_idx  (idx),
    .wr_data (in_data),
    .rd_idx  (idx),
    .rd_data (rd_word)
  );

  bfpq_unpack u_unpack_rd (
    .word   (rd_word),
    .fields (rd_fields)
  );

  bfpq_align_round #(
    .MANT_W (MANT_W)
  ) u_round (
    .fields     (rd_fields),
    .shared_exp (shared_exp),
    .mant       (out_mant)
  );

  assign out_exp  = shared_exp;
  assign out_last = out_valid && at_last;

endmodule

// File: rtl/bfpq_quantizer_chk.sv
module bfpq_quantizer_chk #(
  parameter int BLOCK_LEN = 8,
  parameter int MANT_W    = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic              out_valid,
  input logic              out_ready,
  input logic [MANT_W-1:0] out_mant,
  input logic [7:0]        out_exp,
  input logic              out_last
);

  localparam int CNT_W = $clog2(BLOCK_LEN + 1);

  logic [CNT_W-1:0] acc_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_cnt <= '0;
    end else if (out_valid && out_ready && out_last) begin
      acc_cnt <= '0;
    end else if (in_valid && in_ready) begin
      acc_cnt <= acc_cnt + 1'b1;
    end
  end

  p_reset_state_r1: assert property (@(posedge clk)
    !rst_n |-> (in_ready && !out_valid));

  p_exclusive_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_ready && out_valid));

  p_no_overfill_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |-> (acc_cnt < CNT_W'(BLOCK_LEN)));

  p_drain_after_full_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> (acc_cnt == CNT_W'(BLOCK_LEN)));

  p_zero_block_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_exp == 8'd0) |-> (out_mant == '0));

  p_no_min_code_r5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_mant != {1'b1, {(MANT_W-1){1'b0}}}));

  p_refill_after_last_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && out_last) |=> in_ready);

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_mant) && $stable(out_last)));

  p_exp_steady_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !(out_ready && out_last)) |=> $stable(out_exp));

endmodule

bind bfpq_quantizer bfpq_quantizer_chk #(
  .BLOCK_LEN (BLOCK_LEN),
  .MANT_W    (MANT_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_mant  (out_mant),
  .out_exp   (out_exp),
  .out_last  (out_last)
);

// File: tb/bfpq_quantizer_tb.sv
module bfpq_quantizer_tb;

  localparam int N  = 8;
  localparam int MW = 8;
  localparam int WATCHDOG = 100000;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          in_valid;
  logic          in_ready;
  logic [31:0]   in_data;
  logic          out_valid;
  logic          out_ready;
  logic [MW-1:0] out_mant;
  logic [7:0]    out_exp;
  logic          out_last;

  always #2 clk = ~clk;

  bfpq_quantizer #(.BLOCK_LEN(N), .MANT_W(MW)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_mant(out_mant), .out_exp(out_exp), .out_last(out_last)
  );

  int unsigned stim[$];
  int unsigned blk[$];
  int          exp_m[N];
  string       tag_m[N];
  int          si = 0;
  bit          m_fill = 1'b1;
  int          m_rd = 0;
  int          m_exp = 0;
  int          n_checks = 0;
  int          n_fail = 0;

  // unsaturated rounded magnitude, from the numeric definition
  function automatic int ref_mag(int unsigned w, int e_sh);
    int   e;
    real  q;
    int   mag;
    e = int'((w >> 23) & 32'hFF);
    if (e == 0) return 0;
    q = real'((w & 32'h7FFFFF) + 32'h800000);
    for (int k = 0; k < 17 + (e_sh - e); k++) q = q / 2.0;
    mag = $rtoi(q);
    if (q - real'(mag) >= 0.5) mag = mag + 1;
    return mag;
  endfunction

  function automatic int ref_mant(int unsigned w, int e_sh);
    int mag;
    mag = ref_mag(w, e_sh);
    if (mag > 127) mag = 127;
    return w[31] ? -mag : mag;
  endfunction

  function automatic string ref_tag(int unsigned w, int e_sh);
    int mag;
    if (((w >> 23) & 32'hFF) == 0) return "R6";
    mag = ref_mag(w, e_sh);
    if (mag > 127) return "R5";
    if (mag == 0)  return "R7";
    return "R4";
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, expv, $time);
    end
  endtask

  // behavioural reference, advanced on every rising edge
  always @(posedge clk) begin
    if (!rst_n) begin
      m_fill = 1'b1;
      m_rd   = 0;
      blk.delete();
    end else if (m_fill) begin
      if (in_valid) begin
        blk.push_back(in_data);
        si++;
        if (blk.size() == N) begin
          m_exp = 0;
          foreach (blk[k]) begin
            if (int'((blk[k] >> 23) & 32'hFF) > m_exp) m_exp = int'((blk[k] >> 23) & 32'hFF);
          end
          foreach (blk[k]) begin
            exp_m[k] = ref_mant(blk[k], m_exp);
            tag_m[k] = ref_tag(blk[k], m_exp);
          end
          m_fill = 1'b0;
          m_rd   = 0;
        end
      end
    end else if (out_ready) begin
      m_rd++;
      if (m_rd == N) begin
        m_fill = 1'b1;
        m_rd   = 0;
        blk.delete();
      end
    end
  end

  task automatic add_block(input int unsigned w0, input int unsigned w1, input int unsigned w2,
                           input int unsigned w3, input int unsigned w4, input int unsigned w5,
                           input int unsigned w6, input int unsigned w7);
    stim.push_back(w0); stim.push_back(w1); stim.push_back(w2); stim.push_back(w3);
    stim.push_back(w4); stim.push_back(w5); stim.push_back(w6); stim.push_back(w7);
  endtask

  initial begin
    int  cyc;
    bit  hold;
    logic [MW-1:0] prev_mant;
    bit  burst;

    // zeros and denormals of both signs (R3, R6)
    add_block(32'h00000000, 32'h80000000, 32'h00000001, 32'h807FFFFF,
              32'h00400000, 32'h80000010, 32'h00000000, 32'h007FFFFF);
    // one exponent: saturation, ties, near-ties (R4, R5)
    add_block(32'h3FFFFFFF, 32'hBFFFFFFF, 32'h3F810000, 32'hBF810000,
              32'h3F800000, 32'h3F818000, 32'h3F808000, 32'h3FC00000);
    // wide spread: shifts and flushes (R4, R7)
    add_block(32'h47000000, 32'h3F800000, 32'h46800000, 32'hC6000000,
              32'h45800000, 32'h00000010, 32'h43000000, 32'h44000000);
    // low-edge ties: exactly one half rounds away (R7)
    add_block(32'h3F800000, 32'h3C000000, 32'hBC000000, 32'h3BFFFFFF,
              32'hBBFFFFFF, 32'h3C400000, 32'h80000000, 32'h3E800000);
    // random blocks
    for (int b = 0; b < 24; b++) begin
      for (int k = 0; k < N; k++) begin
        int unsigned e;
        e = ($urandom % 10 == 0) ? 0 : 100 + ($urandom % 40);
        stim.push_back({$urandom % 2 == 0 ? 1'b0 : 1'b1, e[7:0], 23'($urandom)});
      end
    end

    rst_n = 1'b0; in_valid = 1'b0; in_data = '0; out_ready = 1'b0;
    hold = 1'b0; prev_mant = '0;
    for (int r = 0; r < 3; r++) begin
      @(negedge clk);
      chk(in_ready == 1'b1, "R1 in_ready in reset", int'(in_ready), 1);
      chk(out_valid == 1'b0, "R1 out_valid in reset", int'(out_valid), 0);
    end
    rst_n = 1'b1;

    cyc = 0;
    while (!(si == stim.size() && m_fill && blk.size() == 0)) begin
      @(negedge clk);
      cyc++;
      if (cyc > WATCHDOG) begin
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual %0d cycles expected at most %0d", cyc, WATCHDOG);
        break;
      end
      chk(in_ready == m_fill, "R2 in_ready", int'(in_ready), int'(m_fill));
      chk(out_valid == !m_fill, "R2 out_valid", int'(out_valid), int'(!m_fill));
      if (!m_fill) begin
        chk($signed(out_mant) == exp_m[m_rd], tag_m[m_rd], int'($signed(out_mant)), exp_m[m_rd]);
        chk(int'(out_exp) == m_exp, "R3/R10 out_exp", int'(out_exp), m_exp);
        chk(out_last == (m_rd == N-1), "R8 out_last", int'(out_last), int'(m_rd == N-1));
        if (hold) chk(out_mant == prev_mant, "R9 held mantissa", int'(out_mant), int'(prev_mant));
      end
      burst     = ((cyc / 150) % 2) == 0;
      in_valid  = (si < stim.size()) && (burst || ($urandom % 3 != 0));
      in_data   = (si < stim.size()) ? stim[si] : 32'h0;
      out_ready = burst || ($urandom % 3 != 0);
      hold      = out_valid && !out_ready;
      prev_mant = out_mant;
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

endmodule